// File: doc/BRIEF.md
# Ethernet Broadcast Frame Receive Classifier

This block sits behind a stage that assembles line nibbles into bytes. It takes one Ethernet frame at a time as a byte stream. Each byte carries a valid strobe, and a frame-active flag spans the whole frame. The block consumes and checks the synchronisation preamble, then walks the 14-byte MAC header: destination, source and type. It keeps a frame only if the destination is the all-ones broadcast address and the type field carries one of two experimental codes, one for audio samples and one for display data. For a kept frame it forwards the payload bytes, each tagged with the frame's class. Over header and payload it runs a CRC-32 check that also takes in the trailing check bytes. When the frame ends it reports a good or bad verdict, so that downstream logic can throw away a frame whose check fails.

The parser is a single state machine. `S_IDLE` waits for the first byte of a frame. A 0x55 byte moves it to `S_PRE`, and any other byte moves it to `S_DROP`. `S_PRE` counts further 0x55 bytes and moves to `S_DST` on the start byte 0xD5 after exactly seven of them. Any other byte sends it to `S_DROP`. `S_DST` needs six 0xFF bytes and goes to `S_SRC`. `S_SRC` skips six bytes and goes to `S_TYPE`. `S_TYPE` reads two bytes, most significant first, and goes to `S_PAYLOAD` on a known code or to `S_DROP` on any other. `S_PAYLOAD` and `S_DROP` hold until the frame ends. A low frame-active flag sends every state back to `S_IDLE`.

Payload bytes pass through a four-deep delay line. Because of it, the four check bytes at the tail of the frame are never emitted.

Top module: `eth_rx_classifier`

## Requirements
- R1: A frame is tracked only if it opens with seven 0x55 bytes and then 0xD5. Any other byte in those eight positions makes the block ignore the rest of the frame: no payload output and no `frame_done`. The next frame is then received normally.
- R2: After the start byte, the next 6 bytes are the destination, the next 6 the source and the next 2 the type field, with the high type byte first. Payload starts at the 15th byte after the start byte.
- R3: If any destination byte differs from 0xFF, the frame produces neither payload output nor `frame_done`.
- R4: Type 0x0101 gives `pay_class` = 2'b01 (audio), and type 0x0102 gives 2'b10 (display). Any other type value produces neither payload nor `frame_done`.
- R5: An accepted frame emits every byte between the header and the last four bytes, in order, on `pay_byte` with `pay_valid`. Each byte appears in the cycle after the rising edge that samples the byte four positions later. The last four bytes are never emitted.
- R6: The check is the reflected CRC-32 (polynomial 0x04C11DB7, start value all ones, complemented result) over header and payload. The result is sent least significant byte first. `crc_ok` is high with `frame_done` exactly when the register, read most significant bit first, holds the residue 0xC704DD7B after the last byte.
- R7: For a tracked frame, `frame_done` is a one-cycle pulse in the cycle after the first rising edge that samples `frame_active` low. `crc_ok` is never high outside that pulse.
- R8: A tracked frame with fewer than 18 bytes after the start byte, including one that ends inside the header, gives `frame_done` with `crc_ok` low.
- R9: While `rst` is high, `pay_valid`, `frame_done` and `crc_ok` are low. After reset the parser searches for a preamble, so a frame already in progress at release is ignored.
- R10: A byte is taken only when `in_valid` and `frame_active` are both high. Cycles with `in_valid` low have no effect, whatever `in_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` holds a frame byte this cycle |
| in_byte | input | 8 | Received byte |
| frame_active | input | 1 | High for the whole duration of a frame |
| pay_valid | output | 1 | `pay_byte` holds a payload byte |
| pay_byte | output | 8 | Payload byte |
| pay_class | output | 2 | Class of the payload: 01 audio, 10 display |
| frame_done | output | 1 | One-cycle end-of-frame pulse for tracked frames |
| crc_ok | output | 1 | With `frame_done`: the frame passed length and CRC checks |

## Verification
Good audio frames are swept over every payload length from 0 to 24, some with idle gaps that hold decoy bytes. Display frames cover a shorter range. Together these separate correct delay-line emission and output timing from off-by-one payload boundaries. One bit is flipped in turn in each source, payload and check byte, which tells a real CRC comparison from a length-only check. Each destination byte is altered in turn, unknown type codes are sent, and malformed preambles (a wrong byte at each position, one 0x55 too few, one too many) check that filtering is silent. Truncated frames of every length below 18, and a reset in the middle of a frame, check the short-frame verdict and the recovery behaviour.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DST,
        S_SRC,
        S_TYPE,
        S_PAYLOAD,
        S_DROP
    } rx_state_e;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'b00,
        CLS_AUDIO   = 2'b01,
        CLS_DISPLAY = 2'b10
    } rx_class_e;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [7:0]  BCAST_BYTE    = 8'hFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE   = 32'hC704DD7B;

    // One byte step of the LSB-first CRC-32 register.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic       match
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, data);
        end
    end

    // Residue is quoted MSB first; the register runs LSB first.
    assign match = (bit_reverse32(crc_q) == CRC_RESIDUE);

endmodule

// File: rtl/eth_rx_delay.sv
module eth_rx_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         out_valid,
    output logic [W-1:0] dout
);

    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    logic [FW-1:0] fill;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            logic [W-1:0] q;
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else if (push) q <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else if (push) q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            fill      <= '0;
            out_valid <= 1'b0;
            if (rst) dout <= '0;
        end else begin
            out_valid <= push && (fill == FULL);
            if (push) begin
                if (fill != FULL) fill <= fill + 1'b1;
                else              dout <= g_stage[DEPTH-1].q;
            end
        end
    end

    // R5: an emitted byte is always caused by a new byte entering.
    assert_emit_on_push_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(push));

endmodule

// File: rtl/eth_rx_parser.sv
module eth_rx_parser
    import eth_rx_pkg::*;
#(
    parameter int          PRE_LEN      = 8,
    parameter int          ADDR_BYTES   = 6,
    parameter int          FCS_BYTES    = 4,
    parameter logic [15:0] TYPE_AUDIO   = 16'h0101,
    parameter logic [15:0] TYPE_DISPLAY = 16'h0102
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       frame_active,
    input  logic       crc_match,
    output logic       push,
    output logic       crc_en,
    output logic       crc_clear,
    output logic       flush,
    output logic [1:0] cls,
    output logic       frame_done,
    output logic       crc_ok
);

    localparam int HDR_BYTES = 2 * ADDR_BYTES + 2;
    localparam int LEN_MIN   = HDR_BYTES + FCS_BYTES;
    localparam int PW        = $clog2(PRE_LEN);
    localparam int HW        = $clog2(HDR_BYTES);
    localparam int LW        = $clog2(LEN_MIN + 1);
    localparam logic [PW-1:0] PRE_LAST    = PW'(PRE_LEN - 1);
    localparam logic [PW-1:0] PRE_ONE     = PW'(1);
    localparam logic [HW-1:0] DST_LAST    = HW'(ADDR_BYTES - 1);
    localparam logic [HW-1:0] SRC_LAST    = HW'(2 * ADDR_BYTES - 1);
    localparam logic [HW-1:0] TYPE_HI_IDX = HW'(2 * ADDR_BYTES);
    localparam logic [HW-1:0] TYPE_LAST   = HW'(HDR_BYTES - 1);
    localparam logic [LW-1:0] LEN_FULL    = LW'(LEN_MIN);

    rx_state_e     state, next;
    logic [PW-1:0] pre_cnt;
    logic [HW-1:0] hdr_cnt;
    logic [LW-1:0] len_q;
    logic [7:0]    type_hi;
    logic [1:0]    cls_q;
    logic          active_q;

    logic        beat, frame_end, in_frame, type_known;
    logic [15:0] type_code;

    assign beat       = in_valid && frame_active;
    assign frame_end  = active_q && !frame_active;
    assign in_frame   = (state == S_DST) || (state == S_SRC) ||
                        (state == S_TYPE) || (state == S_PAYLOAD);
    assign type_code  = {type_hi, in_byte};
    assign type_known = (type_code == TYPE_AUDIO) || (type_code == TYPE_DISPLAY);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= next;
    end

    // Next-state logic
    always_comb begin
        next = state;
        if (!frame_active) begin
            next = S_IDLE;
        end else if (beat) begin
            unique case (state)
                S_IDLE:    next = (in_byte == PRE_BYTE) ? S_PRE : S_DROP;
                S_PRE: begin
                    if (in_byte == PRE_BYTE && pre_cnt != PRE_LAST) next = S_PRE;
                    else if (in_byte == SFD_BYTE && pre_cnt == PRE_LAST) next = S_DST;
                    else next = S_DROP;
                end
                S_DST: begin
                    if (in_byte != BCAST_BYTE)   next = S_DROP;
                    else if (hdr_cnt == DST_LAST) next = S_SRC;
                end
                S_SRC:     if (hdr_cnt == SRC_LAST) next = S_TYPE;
                S_TYPE:    if (hdr_cnt == TYPE_LAST) next = type_known ? S_PAYLOAD : S_DROP;
                S_PAYLOAD: next = S_PAYLOAD;
                S_DROP:    next = S_DROP;
                default:   next = S_IDLE;
            endcase
        end
    end

    // Output and counter registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt    <= '0;
            hdr_cnt    <= '0;
            len_q      <= '0;
            type_hi    <= '0;
            cls_q      <= CLS_NONE;
            active_q   <= 1'b0;
            frame_done <= 1'b0;
            crc_ok     <= 1'b0;
        end else begin
            active_q   <= frame_active;
            frame_done <= frame_end && in_frame;
            crc_ok     <= frame_end && in_frame && crc_match && (len_q == LEN_FULL);
            if (state == S_IDLE) begin
                hdr_cnt <= '0;
                len_q   <= '0;
                cls_q   <= CLS_NONE;
            end
            if (beat) begin
                if (in_frame && len_q != LEN_FULL) len_q <= len_q + 1'b1;
                unique case (state)
                    S_IDLE: pre_cnt <= PRE_ONE;
                    S_PRE:  pre_cnt <= pre_cnt + 1'b1;
                    S_DST, S_SRC: hdr_cnt <= hdr_cnt + 1'b1;
                    S_TYPE: begin
                        hdr_cnt <= hdr_cnt + 1'b1;
                        if (hdr_cnt == TYPE_HI_IDX) type_hi <= in_byte;
                        if (hdr_cnt == TYPE_LAST) begin
                            if (type_code == TYPE_AUDIO)        cls_q <= CLS_AUDIO;
                            else if (type_code == TYPE_DISPLAY) cls_q <= CLS_DISPLAY;
                        end
                    end
                    S_PAYLOAD, S_DROP: ;
                    default: ;
                endcase
            end
        end
    end

    assign push      = beat && (state == S_PAYLOAD);
    assign crc_en    = beat && in_frame;
    assign crc_clear = (state == S_IDLE);
    assign flush     = frame_end;
    assign cls       = cls_q;

    // R1: the header is entered only straight after the start byte.
    assert_sfd_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_DST && $past(state) == S_PRE) |-> $past(in_byte) == SFD_BYTE);

    // R4: payload state always carries a known class.
    assert_class_known_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAYLOAD) |-> (cls_q == CLS_AUDIO || cls_q == CLS_DISPLAY));

    // R7: done follows a sampled fall of frame_active.
    assert_done_after_fall_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!$past(frame_active) && $past(frame_active, 2)));

    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
    import eth_rx_pkg::*;
#(
    parameter int          PRE_LEN      = 8,
    parameter int          ADDR_BYTES   = 6,
    parameter int          FCS_BYTES    = 4,
    parameter logic [15:0] TYPE_AUDIO   = 16'h0101,
    parameter logic [15:0] TYPE_DISPLAY = 16'h0102
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       frame_active,
    output logic       pay_valid,
    output logic [7:0] pay_byte,
    output logic [1:0] pay_class,
    output logic       frame_done,
    output logic       crc_ok
);

    logic push, crc_en, crc_clear, flush, crc_match;
    logic [1:0] cls;

    eth_rx_parser #(
        .PRE_LEN     (PRE_LEN),
        .ADDR_BYTES  (ADDR_BYTES),
        .FCS_BYTES   (FCS_BYTES),
        .TYPE_AUDIO  (TYPE_AUDIO),
        .TYPE_DISPLAY(TYPE_DISPLAY)
    ) parser_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .frame_active(frame_active),
        .crc_match   (crc_match),
        .push        (push),
        .crc_en      (crc_en),
        .crc_clear   (crc_clear),
        .flush       (flush),
        .cls         (cls),
        .frame_done  (frame_done),
        .crc_ok      (crc_ok)
    );

    eth_rx_crc crc_i (
        .clk  (clk),
        .rst  (rst),
        .clear(crc_clear),
        .en   (crc_en),
        .data (in_byte),
        .match(crc_match)
    );

    eth_rx_delay #(
        .DEPTH(FCS_BYTES),
        .W    (8)
    ) delay_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (push),
        .din      (in_byte),
        .out_valid(pay_valid),
        .dout     (pay_byte)
    );

    assign pay_class = cls;

    // R5: payload output only follows an accepted input byte.
    assert_pay_after_beat_R5: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> $past(in_valid && frame_active));

    // R4: each payload byte carries exactly one class bit.
    assert_pay_class_R4: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> ($countones(pay_class) == 1));

    // R7: the verdict never appears without the done pulse.
    assert_ok_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        crc_ok |-> frame_done);

endmodule

// File: tb/eth_rx_classifier_tb.sv
module eth_rx_classifier_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PS         = 22;   // first payload index in the byte array
    localparam int MAXB       = 128;

    logic       clk = 1'b0;
    logic       rst, in_valid, frame_active;
    logic [7:0] in_byte;
    logic       pay_valid, frame_done, crc_ok;
    logic [7:0] pay_byte;
    logic [1:0] pay_class;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_classifier dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .frame_active(frame_active), .pay_valid(pay_valid), .pay_byte(pay_byte),
        .pay_class(pay_class), .frame_done(frame_done), .crc_ok(crc_ok)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] fr [0:MAXB-1];
    int flen;
    int drv_cyc [0:MAXB-1];
    logic [7:0] got_b [0:MAXB-1];
    logic [1:0] got_c [0:MAXB-1];
    int got_cyc [0:MAXB-1];
    int gcnt, dcnt, done_cyc, fall_cyc;
    logic done_ok;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        if (pay_valid) begin
            if (gcnt < MAXB) begin
                got_b[gcnt] = pay_byte;
                got_c[gcnt] = pay_class;
                got_cyc[gcnt] = cyc;
            end
            gcnt++;
        end
        if (frame_done) begin
            dcnt++;
            done_ok = crc_ok;
            done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_fcs(input int first, input int count);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = first; k < first + count; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ fr[k][b];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic build(input logic [15:0] typ, input int plen, input int seed);
        logic [31:0] f;
        for (int i = 0; i < 7; i++) fr[i] = 8'h55;
        fr[7] = 8'hD5;
        for (int i = 8; i < 14; i++) fr[i] = 8'hFF;
        for (int i = 14; i < 20; i++) fr[i] = 8'(8'h10 + i + seed);
        fr[20] = typ[15:8];
        fr[21] = typ[7:0];
        for (int i = 0; i < plen; i++) fr[PS+i] = 8'((seed * 29 + i * 13 + 7) & 255);
        f = ref_fcs(8, 14 + plen);
        fr[PS+plen]   = f[7:0];
        fr[PS+plen+1] = f[15:8];
        fr[PS+plen+2] = f[23:16];
        fr[PS+plen+3] = f[31:24];
        flen = PS + plen + 4;
    endtask

    task automatic drive(input int n, input bit gaps);
        gcnt = 0;
        dcnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_active = 1'b1;
            in_valid = 1'b1;
            in_byte = fr[i];
            drv_cyc[i] = cyc;
            if (gaps && (i % 3 == 2)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte = 8'hD5;   // decoy, must be ignored (R10)
            end
        end
        @(negedge clk);
        frame_active = 1'b0;
        in_valid = 1'b0;
        in_byte = 8'h00;
        fall_cyc = cyc;
        repeat (5) @(negedge clk);
    endtask

    // exp_pl < 0 means no payload expected
    task automatic expect_frame(input string req, input bit exp_done, input bit exp_ok,
                                input int exp_pl, input logic [1:0] ecls, input bit timing);
        int mm, cm, tm, npl;
        npl = (exp_pl < 0) ? 0 : exp_pl;
        check(dcnt == int'(exp_done), req, "frame_done count", dcnt, int'(exp_done));
        if (exp_done && dcnt == 1) begin
            check(done_ok == exp_ok, req, "crc_ok verdict", int'(done_ok), int'(exp_ok));
            check(done_cyc == fall_cyc + 1, "R7", "frame_done cycle", done_cyc, fall_cyc + 1);
        end
        check(gcnt == npl, req, "payload byte count", gcnt, npl);
        if (gcnt == npl && npl > 0) begin
            mm = 0; cm = 0; tm = 0;
            for (int j = 0; j < npl; j++) begin
                if (got_b[j] != fr[PS+j]) mm++;
                if (got_c[j] != ecls) cm++;
                if (timing && got_cyc[j] != drv_cyc[PS+j+4] + 1) tm++;
            end
            check(mm == 0, "R5", "payload byte mismatches", mm, 0);
            check(cm == 0, "R4", "payload class mismatches", cm, 0);
            if (timing) check(tm == 0, "R5", "payload timing mismatches", tm, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] bad_types [5];
        rst = 1'b1; in_valid = 1'b0; frame_active = 1'b0; in_byte = 8'h00;
        gcnt = 0; dcnt = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(pay_valid == 1'b0, "R9", "pay_valid in reset", int'(pay_valid), 0);
        check(frame_done == 1'b0, "R9", "frame_done in reset", int'(frame_done), 0);
        check(crc_ok == 1'b0, "R9", "crc_ok in reset", int'(crc_ok), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 R5 R6 R10: audio frames of every payload length, gaps on odd lengths
        for (int p = 0; p <= 24; p++) begin
            build(16'h0101, p, p);
            drive(flen, p % 2 == 1);
            expect_frame("R6", 1'b1, 1'b1, p, 2'b01, p % 2 == 0);
        end
        // R4: display frames
        for (int p = 0; p <= 8; p++) begin
            build(16'h0102, p, p + 40);
            drive(flen, 1'b0);
            expect_frame("R4", 1'b1, 1'b1, p, 2'b10, 1'b1);
        end
        // R6: single bit error in source, payload and check bytes
        for (int k = 0; k < 16; k++) begin
            int pos;
            pos = (k < 6) ? 14 + k : 16 + k;
            build(16'h0101, 6, 3);
            fr[pos] = fr[pos] ^ 8'(1 << (k % 8));
            drive(flen, 1'b0);
            expect_frame("R6", 1'b1, 1'b0, 6, 2'b01, 1'b1);
        end
        // R3: non-broadcast destination
        for (int k = 0; k < 6; k++) begin
            build(16'h0101, 5, 9);
            fr[8+k] = 8'hFF ^ 8'(1 << k);
            drive(flen, 1'b0);
            expect_frame("R3", 1'b0, 1'b0, -1, 2'b00, 1'b0);
        end
        // R4: unknown type codes
        bad_types[0] = 16'h0100; bad_types[1] = 16'h0103; bad_types[2] = 16'h0001;
        bad_types[3] = 16'h0201; bad_types[4] = 16'h0000;
        for (int k = 0; k < 5; k++) begin
            build(bad_types[k], 5, 11);
            drive(flen, 1'b0);
            expect_frame("R4", 1'b0, 1'b0, -1, 2'b00, 1'b0);
        end
        // R1: wrong byte at each preamble position
        for (int k = 0; k < 8; k++) begin
            build(16'h0101, 4, 12);
            fr[k] = (k == 7) ? 8'h55 : 8'h54;
            drive(flen, 1'b0);
            expect_frame("R1", 1'b0, 1'b0, -1, 2'b00, 1'b0);
        end
        // R1: six 0x55 then start byte
        build(16'h0101, 4, 13);
        for (int i = 6; i < flen - 1; i++) fr[i] = fr[i+1];
        drive(flen - 1, 1'b0);
        expect_frame("R1", 1'b0, 1'b0, -1, 2'b00, 1'b0);
        // R1: eight 0x55 then start byte
        build(16'h0101, 4, 14);
        for (int i = flen; i > 0; i--) fr[i] = fr[i-1];
        fr[0] = 8'h55;
        drive(flen + 1, 1'b0);
        expect_frame("R1", 1'b0, 1'b0, -1, 2'b00, 1'b0);
        // R1: recovery after a bad preamble
        build(16'h0101, 3, 15);
        drive(flen, 1'b0);
        expect_frame("R1", 1'b1, 1'b1, 3, 2'b01, 1'b1);

        // R8: truncated frames, 0..17 bytes after the start byte
        for (int l = 0; l < 18; l++) begin
            build(16'h0101, 0, 16);
            drive(8 + l, 1'b0);
            expect_frame("R8", 1'b1, 1'b0, -1, 2'b00, 1'b0);
        end
        // R8: minimum-size frame is good
        build(16'h0102, 0, 17);
        drive(flen, 1'b0);
        expect_frame("R8", 1'b1, 1'b1, 0, 2'b10, 1'b0);

        // R9: reset in the middle of a frame
        build(16'h0101, 20, 18);
        gcnt = 0; dcnt = 0;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            frame_active = 1'b1;
            in_valid = 1'b1;
            in_byte = fr[i];
            if (i == 30) rst = 1'b1;
            if (i == 32) begin
                check(pay_valid == 1'b0 && frame_done == 1'b0, "R9", "outputs during reset",
                      int'(pay_valid), 0);
                rst = 1'b0;
                gcnt = 0;
            end
        end
        @(negedge clk);
        frame_active = 1'b0; in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(dcnt == 0, "R9", "done after mid-frame reset", dcnt, 0);
        check(gcnt == 0, "R9", "payload after mid-frame reset", gcnt, 0);
        build(16'h0101, 7, 19);
        drive(flen, 1'b1);
        expect_frame("R9", 1'b1, 1'b1, 7, 2'b01, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule